// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers 32 interrupt request lines into two processor interrupt outputs: one critical, one non-critical. Each request line first passes through a two-flop synchroniser. A per-source trigger bit selects level or edge detection, and a per-source polarity bit selects the active level or edge. A detected request sets a latched pending bit. Software clears a pending bit by writing a one to it.

An enable mask gates the pending bits, and a read-only view shows the gated result. A per-source routing bit sends each enabled pending bit to the critical output or to the non-critical output. A small synchronous register port gives access to all registers.

In every register, source number n sits at bit 31-n, so source 0 is the most significant bit.

Top module: `intc_core`

## Requirements
- R1: After reset, the enable, routing, trigger and polarity registers read 0, the masked view reads 0, and both interrupt outputs are low.
- R2: Source n appears at register bit 31-n. A rising edge on source 0 alone, with edge trigger and high polarity, makes the pending register read 0x80000000.
- R3: A trigger bit of 0 makes the source level-sensitive: the pending bit sets while the input is active. A trigger bit of 1 makes it edge-sensitive, and the pending bit then stays set after the input goes back, until software clears it.
- R4: A polarity bit of 1 makes a source active on a high level or a rising edge. A polarity bit of 0 makes it active on a low level or a falling edge.
- R5: Writing to the pending register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears every pending bit.
- R6: A clear takes effect at the clock edge of the write, and it wins over a new request in that cycle. A level source that is still active reads 0 just after the clear and reads 1 again one clock later.
- R7: The masked view (address 5) equals pending AND enable. A write to address 5 has no effect.
- R8: The critical output is high when any masked bit has its routing bit at 1. The non-critical output is high when any masked bit has its routing bit at 0.
- R9: After an input changes between clock edges, its pending bit is still 0 after two rising edges and is set after the third.
- R10: The register addresses are: 0 pending, 1 enable, 2 routing, 3 trigger, 4 polarity, 5 masked view. Each writable register reads back the value last written to it. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Raw request lines; srcIn[n] is source n |
| regSel | input | 1 | Register access select |
| regWr | input | 1 | Write when high, read when low |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the same cycle as the address |
| critIrq | output | 1 | Critical interrupt request |
| nonCritIrq | output | 1 | Non-critical interrupt request |

## Verification
The assertions run on every cycle. They check that a pending bit falls only when a write-one-to-clear targets it, and that a write to the masked view leaves the configuration untouched. They also check that each output is high only when some masked bit is routed to it. The following can only be shown by the bench's scenarios:
- the synchroniser latency;
- level and edge detection under each polarity;
- the one-cycle dip of a level source after a clear;
- the bit order of the sources.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 3'd0,
    ADDR_ENABLE = 3'd1,
    ADDR_CRIT   = 3'd2,
    ADDR_TRIG   = 3'd3,
    ADDR_POL    = 3'd4,
    ADDR_MASKED = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic     wrStatus;
    logic     wrEnable;
    logic     wrCrit;
    logic     wrTrig;
    logic     wrPol;
    logic     rdValid;
    regAddr_e rdSel;
  } regStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobes_t       strobes
);
  logic wrAccess;
  assign wrAccess = regSel & regWr;

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = ADDR_STATUS;
    case (regAddr)
      ADDR_STATUS: begin strobes.wrStatus = wrAccess; strobes.rdValid = regSel; strobes.rdSel = ADDR_STATUS; end
      ADDR_ENABLE: begin strobes.wrEnable = wrAccess; strobes.rdValid = regSel; strobes.rdSel = ADDR_ENABLE; end
      ADDR_CRIT:   begin strobes.wrCrit   = wrAccess; strobes.rdValid = regSel; strobes.rdSel = ADDR_CRIT;   end
      ADDR_TRIG:   begin strobes.wrTrig   = wrAccess; strobes.rdValid = regSel; strobes.rdSel = ADDR_TRIG;   end
      ADDR_POL:    begin strobes.wrPol    = wrAccess; strobes.rdValid = regSel; strobes.rdSel = ADDR_POL;    end
      ADDR_MASKED: begin strobes.rdValid  = regSel;   strobes.rdSel   = ADDR_MASKED; end
      default:     begin strobes.rdValid  = 1'b0; end
    endcase
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcIn,
  input  regStrobes_t     strobes,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdData,
  output logic [NSRC-1:0] statusQ,
  output logic [NSRC-1:0] enableQ,
  output logic [NSRC-1:0] critQ,
  output logic [NSRC-1:0] maskedView,
  output logic            critIrq,
  output logic            nonCritIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NSRC-1:0] syncQ [SYNC_STAGES];
  logic [NSRC-1:0] prevQ;
  logic [NSRC-1:0] trigQ, polQ;
  logic [NSRC-1:0] curBits, prevBits;
  logic [NSRC-1:0] levelHit, edgeHit, setVec, clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  // source n lands on register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_order
    assign curBits[NSRC-1-n]  = syncQ[LAST][n];
    assign prevBits[NSRC-1-n] = prevQ[n];
  end

  assign levelHit = ~(curBits ^ polQ);
  assign edgeHit  = (curBits ^ prevBits) & levelHit;
  assign setVec   = (trigQ & edgeHit) | (~trigQ & levelHit);
  assign clrVec   = strobes.wrStatus ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      critQ   <= '0;
      trigQ   <= '0;
      polQ    <= '0;
    end else begin
      statusQ <= (statusQ | setVec) & ~clrVec;
      if (strobes.wrEnable) enableQ <= wdata;
      if (strobes.wrCrit)   critQ   <= wdata;
      if (strobes.wrTrig)   trigQ   <= wdata;
      if (strobes.wrPol)    polQ    <= wdata;
    end
  end

  assign maskedView = statusQ & enableQ;
  assign critIrq    = |(maskedView & critQ);
  assign nonCritIrq = |(maskedView & ~critQ);

  always_comb begin
    rdData = '0;
    if (strobes.rdValid) begin
      case (strobes.rdSel)
        ADDR_STATUS: rdData = statusQ;
        ADDR_ENABLE: rdData = enableQ;
        ADDR_CRIT:   rdData = critQ;
        ADDR_TRIG:   rdData = trigQ;
        ADDR_POL:    rdData = polQ;
        ADDR_MASKED: rdData = maskedView;
        default:     rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NSRC-1:0]   regWdata,
  output logic [NSRC-1:0]   regRdata,
  output logic              critIrq,
  output logic              nonCritIrq
);
  regStrobes_t     strobes;
  logic [NSRC-1:0] statusQ, enableQ, critQ, maskedView;

  intc_ctrl ctrl_i (
    .regSel (regSel),
    .regWr  (regWr),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  intc_datapath #(.NSRC(NSRC), .SYNC_STAGES(2)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .strobes   (strobes),
    .wdata     (regWdata),
    .rdData    (regRdata),
    .statusQ   (statusQ),
    .enableQ   (enableQ),
    .critQ     (critQ),
    .maskedView(maskedView),
    .critIrq   (critIrq),
    .nonCritIrq(nonCritIrq)
  );
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [NSRC-1:0]   regWdata,
  input logic [NSRC-1:0]   statusQ,
  input logic [NSRC-1:0]   enableQ,
  input logic [NSRC-1:0]   critQ,
  input logic [NSRC-1:0]   maskedView,
  input logic              critIrq,
  input logic              nonCritIrq
);
  logic [NSRC-1:0] chkClr;
  logic            maskedWrite;
  assign chkClr      = (regSel && regWr && regAddr == 3'd0) ? regWdata : '0;
  assign maskedWrite = regSel && regWr && regAddr == 3'd5;

  // pending bits drop only under a write-one-to-clear
  assert_pending_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusQ) & ~$past(chkClr)) & ~statusQ) == '0));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chkClr != '0) |=> ((statusQ & $past(chkClr)) == '0));

  assert_masked_readonly_R7: assert property (@(posedge clk) disable iff (!rstN)
    maskedWrite |=> ($stable(enableQ) && $stable(critQ)));

  assert_crit_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    critIrq |-> ((maskedView & critQ) != '0));

  assert_noncrit_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    nonCritIrq |-> ((maskedView & ~critQ) != '0));
endmodule

bind intc_core intc_core_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .statusQ(statusQ), .enableQ(enableQ), .critQ(critQ),
  .maskedView(maskedView), .critIrq(critIrq), .nonCritIrq(nonCritIrq)
);

// File: tb/intc_core_tb.sv
module intc_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        regSel = 1'b0, regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        critIrq, nonCritIrq;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  intc_core dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .critIrq(critIrq), .nonCritIrq(nonCritIrq)
  );

  // fields: trigger, polarity, start level, end level, enable, routing
  localparam logic [31:0] VEC [4][6] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0F0F_0000, 32'hFFFF_0000, 32'hFF00_0000},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h0000_FFFF},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_FFFF, 32'h0000_0000},
    '{32'hAAAA_AAAA, 32'hCCCC_CCCC, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h5A5A_5A5A, 32'h3333_3333}
  };

  function automatic logic [31:0] toPins(input logic [31:0] v);
    for (int n = 0; n < 32; n++) toPins[n] = v[31-n];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regSel = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    #1 d = regRdata;
    regSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, trg, pl, st, en, exp;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    regRead(3'd1, rd); check("R1 enable", rd, 32'h0);
    regRead(3'd2, rd); check("R1 routing", rd, 32'h0);
    regRead(3'd3, rd); check("R1 trigger", rd, 32'h0);
    regRead(3'd4, rd); check("R1 polarity", rd, 32'h0);
    regRead(3'd5, rd); check("R1 masked", rd, 32'h0);
    check("R1 outputs", {30'd0, critIrq, nonCritIrq}, 32'h0);

    // vector table: R3 R4 R7 R8
    for (int v = 0; v < 4; v++) begin
      trg = VEC[v][0]; pl = VEC[v][1]; st = VEC[v][2]; en = VEC[v][4];
      regWrite(3'd3, trg);
      regWrite(3'd4, pl);
      regWrite(3'd1, en);
      regWrite(3'd2, VEC[v][5]);
      srcIn = toPins(st);
      idle(5);
      regWrite(3'd0, 32'hFFFF_FFFF);
      srcIn = toPins(VEC[v][3]);
      idle(6);
      exp = (trg & ((pl & ~st & VEC[v][3]) | (~pl & st & ~VEC[v][3])))
          | (~trg & ((pl & (st | VEC[v][3])) | (~pl & (~st | ~VEC[v][3]))));
      regRead(3'd0, rd); check($sformatf("R3/R4 pending vec%0d", v), rd, exp);
      regRead(3'd5, rd); check($sformatf("R7 masked vec%0d", v), rd, exp & en);
      check($sformatf("R8 crit vec%0d", v), {31'd0, critIrq}, {31'd0, |(exp & en & VEC[v][5])});
      check($sformatf("R8 noncrit vec%0d", v), {31'd0, nonCritIrq}, {31'd0, |(exp & en & ~VEC[v][5])});
    end

    // R10 readback and unmapped address
    regWrite(3'd1, 32'h1357_9BDF);
    regRead(3'd1, rd); check("R10 enable readback", rd, 32'h1357_9BDF);
    regRead(3'd7, rd); check("R10 unmapped read", rd, 32'h0);

    // R7 write to masked view ignored
    regWrite(3'd5, 32'h0);
    regRead(3'd1, rd); check("R7 masked write ignored", rd, 32'h1357_9BDF);

    // R2 and R9: edge on source 0, latency
    regWrite(3'd3, 32'hFFFF_FFFF);
    regWrite(3'd4, 32'hFFFF_FFFF);
    srcIn = '0;
    idle(4);
    regWrite(3'd0, 32'hFFFF_FFFF);
    srcIn[0] = 1'b1;
    idle(1); regRead(3'd0, rd); check("R9 after one edge", rd, 32'h0);
    idle(1); regRead(3'd0, rd); check("R9 after two edges", rd, 32'h0);
    idle(1); regRead(3'd0, rd); check("R2/R9 source0 at bit31", rd, 32'h8000_0000);
    // R3 edge latched after input returns
    srcIn[0] = 1'b0;
    idle(5); regRead(3'd0, rd); check("R3 edge stays latched", rd, 32'h8000_0000);

    // R5 W1C: zero bits untouched, one bits cleared
    srcIn[4] = 1'b1;
    idle(4);
    regWrite(3'd0, 32'h0000_0000);
    regRead(3'd0, rd); check("R5 zero write no effect", rd, 32'h8800_0000);
    regWrite(3'd0, 32'h0800_0000);
    regRead(3'd0, rd); check("R5 one clears bit", rd, 32'h8000_0000);
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, rd); check("R5 all clear", rd, 32'h0);

    // R6 level source re-sets one cycle after clear
    regWrite(3'd3, 32'h0);
    srcIn = '0;
    srcIn[5] = 1'b1;
    idle(4);
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, rd); check("R6 cleared in write cycle", rd, 32'h0);
    idle(1);
    regRead(3'd0, rd); check("R6 level sets again", rd, 32'h0400_0000);
    // R4 low polarity level
    regWrite(3'd4, 32'hFBFF_FFFF);
    regWrite(3'd0, 32'hFFFF_FFFF);
    idle(1);
    regRead(3'd0, rd); check("R4 high input inactive at low polarity", rd, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule